// File: doc/BRIEF.md
# Script Transfer Control Unit

This block carries out the branch-type instructions of a script sequencer. Each cycle it may be offered one instruction: a command byte, a 23-bit condition field and a 32-bit operand. It acts on the instruction only when the class bits of the command byte mark it as a transfer control instruction. It then decodes one of four operations: jump, call, return or interrupt.

A condition is built from up to three tests. The first compares the current bus phase with an expected phase. The second compares the first incoming asynchronous byte with an expected byte under a mask. The third tests the ALU carry flag. The combined result can be inverted by a sense bit. When the operation is allowed, the block loads the program counter from the operand or from its single return register. For an interrupt it instead latches the operand as a vector, raises an interrupt line and stalls until it is cleared. When the operation is not allowed, execution steps on to the next 8-byte instruction.

The instruction fetch, the phase detector and the ALU sit outside. The block holds only the program counter, the return register and the interrupt state.

Top module: `script_xfer_ctl`

## Requirements
- R1: An instruction is accepted only when cmd_i[7:6] equals 2'b10. For any other class value, pc_o stays the same and done_o, taken_o and err_o remain 0.
- R2: Operation code cmd_i[5:3] is 000 jump, 001 call, 010 return, 011 interrupt. Codes 100 to 111, or nonzero cmd_i[2:0], make err_o high for one cycle, leave pc_o unchanged and keep done_o at 0.
- R3: When a legal instruction is accepted and its effective condition is false, pc_o becomes pc_o + 8 on the next cycle, with done_o=1 and taken_o=0.
- R4: A taken jump loads pc_o with opnd_i, with done_o=1 and taken_o=1.
- R5: A taken call saves pc_o + 8 in the return register and loads pc_o with opnd_i.
- R6: A taken return loads pc_o from the return register, which holds the reset PC value before the first call.
- R7: Phase test: when fld_i[22] is 1, the test passes only if phase_i equals fld_i[18:16].
- R8: Byte test: when fld_i[21] is 1, each bit of in_byte_i is compared with fld_i[7:0], except bits whose mask bit fld_i[15:8] is 1, which are excluded.
- R9: Carry test: when fld_i[20] is 1, the test passes only if carry_i is 1.
- R10: The condition is true only if all enabled tests pass. It is always true when no test is enabled.
- R11: Sense bit fld_i[19]: when it is 1 the operation acts on a true condition, and when it is 0 it acts on a false condition.
- R12: A taken interrupt latches opnd_i on irq_vec_o, raises irq_o and halt_o, and sets pc_o to pc_o + 8. While halt_o is high, instructions are ignored. irq_clr_i drops irq_o and halt_o on the next cycle.
- R13: After reset, pc_o equals RESET_PC and done_o, taken_o, err_o, irq_o, halt_o and irq_vec_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_vld_i | input | 1 | Instruction presented this cycle |
| cmd_i | input | 8 | Command byte: class, operation, reserved |
| fld_i | input | 23 | Condition field: enables, sense, phase, mask, byte |
| opnd_i | input | PC_W | Target address or interrupt vector |
| phase_i | input | 3 | Current bus phase |
| in_byte_i | input | 8 | First incoming asynchronous byte |
| carry_i | input | 1 | ALU carry flag |
| irq_clr_i | input | 1 | Clears the interrupt and the halt |
| pc_o | output | PC_W | Program counter |
| done_o | output | 1 | Legal instruction completed last cycle |
| taken_o | output | 1 | The completed instruction acted |
| err_o | output | 1 | Illegal encoding seen last cycle |
| irq_o | output | 1 | Interrupt request |
| irq_vec_o | output | PC_W | Latched interrupt vector |
| halt_o | output | 1 | Sequencer stalled by interrupt |

## Verification
The decision path is tried with no test enabled under both sense values, which separates the default-true rule from the inversion. Each test is then enabled alone with a passing input and a failing input, which isolates the phase compare, the carry test and the masked byte compare. The masked compare uses a byte that differs from the expected value only in masked bits, and another that differs in an unmasked bit. A mixed case where one enabled test fails shows that the tests are combined with AND and not OR. Call followed by return, and an interrupt followed by an ignored jump and a clear, tell apart the return register, the halt and the vector latch.

// File: rtl/xfer_ctl_pkg.sv
package xfer_ctl_pkg;

  localparam int unsigned PHASE_W = 3;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned FLD_W   = 23;

  localparam logic [1:0] CLASS_XFER = 2'b10;

  // condition field positions
  localparam int unsigned F_BYTE_LSB  = 0;
  localparam int unsigned F_MASK_LSB  = 8;
  localparam int unsigned F_PHASE_LSB = 16;
  localparam int unsigned F_SENSE     = 19;
  localparam int unsigned F_CARRY_EN  = 20;
  localparam int unsigned F_BYTE_EN   = 21;
  localparam int unsigned F_PHASE_EN  = 22;

  typedef enum logic [2:0] {
    OP_JUMP = 3'b000,
    OP_CALL = 3'b001,
    OP_RET  = 3'b010,
    OP_INT  = 3'b011
  } xfer_op_e;

  typedef struct packed {
    logic               phase_en;
    logic               byte_en;
    logic               carry_en;
    logic               sense;
    logic [PHASE_W-1:0] exp_phase;
    logic [BYTE_W-1:0]  mask;
    logic [BYTE_W-1:0]  exp_byte;
  } cond_cfg_t;

  function automatic cond_cfg_t unpack_fld(input logic [FLD_W-1:0] f);
    cond_cfg_t c;
    c.phase_en  = f[F_PHASE_EN];
    c.byte_en   = f[F_BYTE_EN];
    c.carry_en  = f[F_CARRY_EN];
    c.sense     = f[F_SENSE];
    c.exp_phase = f[F_PHASE_LSB +: PHASE_W];
    c.mask      = f[F_MASK_LSB +: BYTE_W];
    c.exp_byte  = f[F_BYTE_LSB +: BYTE_W];
    return c;
  endfunction

endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
  import xfer_ctl_pkg::*;
(
  input  logic [7:0] cmd_i,
  output logic       is_xfer_o,
  output xfer_op_e   op_o,
  output logic       legal_o
);

  logic [2:0] op_raw;
  logic       op_known;

  assign op_raw    = cmd_i[5:3];
  assign is_xfer_o = (cmd_i[7:6] == CLASS_XFER);

  always_comb begin
    op_known = 1'b0;
    op_o     = OP_JUMP;
    unique case (op_raw)
      3'b000:  begin op_o = OP_JUMP; op_known = 1'b1; end
      3'b001:  begin op_o = OP_CALL; op_known = 1'b1; end
      3'b010:  begin op_o = OP_RET;  op_known = 1'b1; end
      3'b011:  begin op_o = OP_INT;  op_known = 1'b1; end
      default: begin op_o = OP_JUMP; op_known = 1'b0; end
    endcase
  end

  // reserved low bits must be zero
  assign legal_o = op_known && (cmd_i[2:0] == 3'b000);

endmodule

// File: rtl/xfer_cond.sv
module xfer_cond
  import xfer_ctl_pkg::*;
(
  input  cond_cfg_t          cfg_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [BYTE_W-1:0]  in_byte_i,
  input  logic               carry_i,
  output logic               act_o
);

  logic [BYTE_W-1:0] bit_ok;
  logic phase_ok, byte_ok, carry_ok, cond;

  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    assign bit_ok[b] = cfg_i.mask[b] | (in_byte_i[b] ~^ cfg_i.exp_byte[b]);
  end

  assign phase_ok = !cfg_i.phase_en || (phase_i == cfg_i.exp_phase);
  assign byte_ok  = !cfg_i.byte_en  || (&bit_ok);
  assign carry_ok = !cfg_i.carry_en || carry_i;
  assign cond     = phase_ok && byte_ok && carry_ok;

  // sense=1: act on true, sense=0: act on false
  assign act_o = cfg_i.sense ? cond : !cond;

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_ctl_pkg::*;
#(
  parameter int unsigned     PC_W     = 32,
  parameter int unsigned     STEP     = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vld_i,
  input  logic            is_xfer_i,
  input  logic            legal_i,
  input  xfer_op_e        op_i,
  input  logic            act_i,
  input  logic [PC_W-1:0] opnd_i,
  input  logic            irq_clr_i,
  output logic [PC_W-1:0] pc_o,
  output logic            done_o,
  output logic            taken_o,
  output logic            err_o,
  output logic            irq_o,
  output logic [PC_W-1:0] irq_vec_o,
  output logic            halt_o
);

  localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

  logic [PC_W-1:0] pc_q, ret_q, vec_q, pc_seq;
  logic            done_q, taken_q, err_q, irq_q, halt_q;
  logic            accept;

  assign accept = vld_i && !halt_q && is_xfer_i;
  assign pc_seq = pc_q + STEP_V;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= RESET_PC;
      ret_q   <= RESET_PC;
      vec_q   <= '0;
      done_q  <= 1'b0;
      taken_q <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      taken_q <= 1'b0;
      err_q   <= 1'b0;
      if (irq_clr_i) begin
        irq_q  <= 1'b0;
        halt_q <= 1'b0;
      end
      if (accept) begin
        if (!legal_i) begin
          err_q <= 1'b1;
        end else begin
          done_q  <= 1'b1;
          taken_q <= act_i;
          if (!act_i) begin
            pc_q <= pc_seq;
          end else begin
            unique case (op_i)
              OP_JUMP: pc_q <= opnd_i;
              OP_CALL: begin
                ret_q <= pc_seq;
                pc_q  <= opnd_i;
              end
              OP_RET:  pc_q <= ret_q;
              OP_INT: begin
                vec_q  <= opnd_i;
                irq_q  <= 1'b1;
                halt_q <= 1'b1;
                pc_q   <= pc_seq;
              end
              default: pc_q <= pc_seq;
            endcase
          end
        end
      end
    end
  end

  assign pc_o      = pc_q;
  assign done_o    = done_q;
  assign taken_o   = taken_q;
  assign err_o     = err_q;
  assign irq_o     = irq_q;
  assign irq_vec_o = vec_q;
  assign halt_o    = halt_q;

  p_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !is_xfer_i) |=> ($stable(pc_q) && !done_q && !err_q));

  p_illegal_err_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !legal_i) |=> (err_q && !done_q && $stable(pc_q)));

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && legal_i && !act_i) |=> (pc_q == $past(pc_q) + STEP_V));

  p_call_save_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && legal_i && act_i && op_i == OP_CALL) |=>
      (ret_q == $past(pc_q) + STEP_V && pc_q == $past(opnd_i)));

  p_ret_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && legal_i && act_i && op_i == OP_RET) |=> (pc_q == $past(ret_q)));

  p_halt_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_q && !irq_clr_i) |=> ($stable(pc_q) && halt_q && !done_q));

  p_irq_halt_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> halt_q);

  p_one_result_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_q, err_q}));

endmodule

// File: rtl/script_xfer_ctl.sv
module script_xfer_ctl
  import xfer_ctl_pkg::*;
#(
  parameter int unsigned     PC_W     = 32,
  parameter int unsigned     STEP     = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_vld_i,
  input  logic [7:0]         cmd_i,
  input  logic [FLD_W-1:0]   fld_i,
  input  logic [PC_W-1:0]    opnd_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [BYTE_W-1:0]  in_byte_i,
  input  logic               carry_i,
  input  logic               irq_clr_i,
  output logic [PC_W-1:0]    pc_o,
  output logic               done_o,
  output logic               taken_o,
  output logic               err_o,
  output logic               irq_o,
  output logic [PC_W-1:0]    irq_vec_o,
  output logic               halt_o
);

  logic      is_xfer, legal, act;
  xfer_op_e  op;
  cond_cfg_t cfg;

  assign cfg = unpack_fld(fld_i);

  xfer_decode u_dec (
    .cmd_i     (cmd_i),
    .is_xfer_o (is_xfer),
    .op_o      (op),
    .legal_o   (legal)
  );

  xfer_cond u_cond (
    .cfg_i     (cfg),
    .phase_i   (phase_i),
    .in_byte_i (in_byte_i),
    .carry_i   (carry_i),
    .act_o     (act)
  );

  xfer_seq #(
    .PC_W     (PC_W),
    .STEP     (STEP),
    .RESET_PC (RESET_PC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (instr_vld_i),
    .is_xfer_i (is_xfer),
    .legal_i   (legal),
    .op_i      (op),
    .act_i     (act),
    .opnd_i    (opnd_i),
    .irq_clr_i (irq_clr_i),
    .pc_o      (pc_o),
    .done_o    (done_o),
    .taken_o   (taken_o),
    .err_o     (err_o),
    .irq_o     (irq_o),
    .irq_vec_o (irq_vec_o),
    .halt_o    (halt_o)
  );

endmodule

// File: tb/script_xfer_ctl_tb_top.sv
`timescale 1ns/1ps
module script_xfer_ctl_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_vld_i = 1'b0;
  logic [7:0]  cmd_i = '0;
  logic [22:0] fld_i = '0;
  logic [31:0] opnd_i = '0;
  logic [2:0]  phase_i = '0;
  logic [7:0]  in_byte_i = '0;
  logic        carry_i = 1'b0;
  logic        irq_clr_i = 1'b0;
  logic [31:0] pc_o, irq_vec_o;
  logic        done_o, taken_o, err_o, irq_o, halt_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_pc = '0;

  always #4 clk_i = ~clk_i;

  script_xfer_ctl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .instr_vld_i(instr_vld_i), .cmd_i(cmd_i),
    .fld_i(fld_i), .opnd_i(opnd_i), .phase_i(phase_i), .in_byte_i(in_byte_i),
    .carry_i(carry_i), .irq_clr_i(irq_clr_i), .pc_o(pc_o), .done_o(done_o),
    .taken_o(taken_o), .err_o(err_o), .irq_o(irq_o), .irq_vec_o(irq_vec_o),
    .halt_o(halt_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // op: 0 jump, 1 call, 2 ret, 3 int
  function automatic logic [7:0] mk_cmd(input logic [2:0] op);
    return {2'b10, op, 3'b000};
  endfunction

  function automatic logic [22:0] mk_fld(input logic pe, input logic be, input logic ce,
                                         input logic sense, input logic [2:0] ph,
                                         input logic [7:0] mask, input logic [7:0] eb);
    return {pe, be, ce, sense, ph, mask, eb};
  endfunction

  // drive at negedge, result sampled at following negedge
  task automatic issue(input logic [7:0] c, input logic [22:0] f, input logic [31:0] o);
    cmd_i = c; fld_i = f; opnd_i = o; instr_vld_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    instr_vld_i = 1'b0;
  endtask

  task automatic expect_step(input string req, input logic taken);
    if (taken) chk({req, " taken pc"}, pc_o, opnd_i);
    else       chk({req, " step pc"}, pc_o, exp_pc + 32'd8);
    chk({req, " done"}, {31'd0, done_o}, 32'd1);
    chk({req, " taken"}, {31'd0, taken_o}, {31'd0, taken});
    exp_pc = pc_o;
  endtask

  task automatic t_reset;
    chk("R13 pc", pc_o, 32'h0);
    chk("R13 flags", {27'd0, done_o, taken_o, err_o, irq_o, halt_o}, 32'd0);
    chk("R13 vec", irq_vec_o, 32'h0);
  endtask

  task automatic t_gate;
    issue(8'hC0, mk_fld(0,0,0,1,0,0,0), 32'h0000_4000);
    chk("R1 pc held", pc_o, exp_pc);
    chk("R1 no done/err", {30'd0, done_o, err_o}, 32'd0);
    issue(8'h40, mk_fld(0,0,0,1,0,0,0), 32'h0000_4000);
    chk("R1 pc held class01", pc_o, exp_pc);
  endtask

  task automatic t_default;
    issue(mk_cmd(3'd0), mk_fld(0,0,0,1,0,0,0), 32'h0000_0100);
    expect_step("R10 R4 no-test jump", 1'b1);
    issue(mk_cmd(3'd0), mk_fld(0,0,0,0,0,0,0), 32'h0000_0900);
    expect_step("R11 R3 sense0 no-test", 1'b0);
  endtask

  task automatic t_phase;
    phase_i = 3'd5;
    issue(mk_cmd(3'd0), mk_fld(1,0,0,1,3'd5,0,0), 32'h0000_0200);
    expect_step("R7 phase match", 1'b1);
    issue(mk_cmd(3'd0), mk_fld(1,0,0,1,3'd4,0,0), 32'h0000_0A00);
    expect_step("R7 phase mismatch", 1'b0);
    issue(mk_cmd(3'd0), mk_fld(1,0,0,0,3'd4,0,0), 32'h0000_0300);
    expect_step("R11 phase mismatch sense0", 1'b1);
  endtask

  task automatic t_byte;
    in_byte_i = 8'hA3;
    issue(mk_cmd(3'd0), mk_fld(0,1,0,1,0,8'h0F,8'hA5), 32'h0000_0400);
    expect_step("R8 masked bits differ", 1'b1);
    in_byte_i = 8'h25;
    issue(mk_cmd(3'd0), mk_fld(0,1,0,1,0,8'h0F,8'hA5), 32'h0000_0B00);
    expect_step("R8 unmasked bit differs", 1'b0);
  endtask

  task automatic t_carry;
    carry_i = 1'b1;
    issue(mk_cmd(3'd0), mk_fld(0,0,1,1,0,0,0), 32'h0000_0500);
    expect_step("R9 carry set", 1'b1);
    carry_i = 1'b0;
    issue(mk_cmd(3'd0), mk_fld(0,0,1,1,0,0,0), 32'h0000_0C00);
    expect_step("R9 carry clear", 1'b0);
  endtask

  task automatic t_all;
    phase_i = 3'd2; carry_i = 1'b0;
    issue(mk_cmd(3'd0), mk_fld(1,0,1,1,3'd2,0,0), 32'h0000_0D00);
    expect_step("R10 one enabled test fails", 1'b0);
    carry_i = 1'b1;
    issue(mk_cmd(3'd0), mk_fld(1,0,1,1,3'd2,0,0), 32'h0000_0600);
    expect_step("R10 all enabled pass", 1'b1);
  endtask

  task automatic t_call_ret;
    logic [31:0] back;
    back = exp_pc + 32'd8;
    issue(mk_cmd(3'd1), mk_fld(0,0,0,1,0,0,0), 32'h0000_2000);
    expect_step("R5 call", 1'b1);
    issue(mk_cmd(3'd2), mk_fld(0,0,0,1,0,0,0), 32'hDEAD_0000);
    chk("R6 return pc", pc_o, back);
    chk("R6 return taken", {31'd0, taken_o}, 32'd1);
    exp_pc = pc_o;
  endtask

  task automatic t_illegal;
    issue({2'b10, 3'b101, 3'b000}, mk_fld(0,0,0,1,0,0,0), 32'h0000_7000);
    chk("R2 err op101", {31'd0, err_o}, 32'd1);
    chk("R2 pc held", pc_o, exp_pc);
    chk("R2 no done", {31'd0, done_o}, 32'd0);
    issue({2'b10, 3'b000, 3'b010}, mk_fld(0,0,0,1,0,0,0), 32'h0000_7000);
    chk("R2 err reserved bits", {31'd0, err_o}, 32'd1);
    chk("R2 pc held reserved", pc_o, exp_pc);
    @(negedge clk_i);
    chk("R2 err one cycle", {31'd0, err_o}, 32'd0);
  endtask

  task automatic t_irq;
    issue(mk_cmd(3'd3), mk_fld(0,0,0,1,0,0,0), 32'hCAFE_0042);
    chk("R12 pc step", pc_o, exp_pc + 32'd8);
    chk("R12 vec", irq_vec_o, 32'hCAFE_0042);
    chk("R12 irq/halt", {30'd0, irq_o, halt_o}, 32'd3);
    exp_pc = pc_o;
    issue(mk_cmd(3'd0), mk_fld(0,0,0,1,0,0,0), 32'h0000_8000);
    chk("R12 ignored while halted", pc_o, exp_pc);
    chk("R12 no done while halted", {31'd0, done_o}, 32'd0);
    irq_clr_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    irq_clr_i = 1'b0;
    chk("R12 cleared", {30'd0, irq_o, halt_o}, 32'd0);
    issue(mk_cmd(3'd0), mk_fld(0,0,0,1,0,0,0), 32'h0000_8000);
    expect_step("R12 resumes", 1'b1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_gate();
        t_default();
        t_phase();
        t_byte();
        t_carry();
        t_all();
        t_call_ret();
        t_illegal();
        t_irq();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule